// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Signature and Readback Registers

This block is a serial test port that follows the IEEE 1149.1 state machine. It is clocked by the test clock, steered by the mode-select line and fed by the serial data input. It holds an instruction register and several data registers: a one-bit bypass stage, a 32-bit identification word, a 16-bit signature word and a readback register that stands in for configuration memory. A chain of boundary cells covers the input-only pins and the bidirectional pins. The port can sample the pins, preload values and drive them onto the bidirectional pins, or float every bidirectional pin at once.

There is no dedicated test-reset pin. The controller starts in Test-Logic-Reset when the power-on reset pulse is high, and TMS can return it there at any time. A lock input stops configuration readback, so the readback register captures zeros while the lock is set. The signature word can be read with the lock set or clear. Serial output is updated on the falling test-clock edge. It is marked valid only in the two shift states.

Top module: `sigtap`

## Requirements
- R1: When `por` is high, or after any five consecutive TCK rising edges with TMS high, the controller is in Test-Logic-Reset and the instruction register holds IDCODE (4'h2).
- R2: In Capture-IR the instruction shift stage loads 4'b0001. Bits shift out LSB first, so the first two bits seen on TDO are 1 and then 0.
- R3: IDCODE selects the 32-bit identification register. It shifts out the ID_CODE parameter LSB first, and bit 0 is always 1.
- R4: BYPASS (4'hF), and every opcode not listed in these requirements, selects a one-bit register that captures 0. Data therefore passes from TDI to TDO one shift late.
- R5: SAMPLE (4'h1) selects the boundary chain. Bit 0 is nearest TDO. Input cell i is at bit i. Bidirectional cell k uses bit N_IN+3k for the pin input, N_IN+3k+1 for the core output value and N_IN+3k+2 for the core output enable. Capture-DR loads all of these.
- R6: In Update-DR with SAMPLE or EXTEST selected, each bidirectional cell copies its shifted output and enable bits into update stages. While EXTEST (4'h0) is selected, the pins take their value and enable from those update stages, and changes to the core value have no effect.
- R7: HIGHZ (4'h3) forces every bidirectional output enable to 0 and selects the bypass register.
- R8: SIGNATURE (4'h4) shifts out the 16-bit SIG_VALUE LSB first, whether the lock is set or clear.
- R9: READBACK (4'h5) captures `cfg_data` when the lock is clear and all zeros when the lock is set.
- R10: TDO changes on the falling edge of TCK. `tdo_en` is 1 only while the controller is in Shift-IR or Shift-DR.
- R11: With any instruction other than EXTEST or HIGHZ, the bidirectional pins carry the core output value and enable unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| tdo_en | output | 1 | TDO valid / drive enable |
| lock | input | 1 | Security lock; blocks readback |
| cfg_data | input | RB_W | Configuration word that the readback register captures |
| in_pins | input | N_IN | Input-only pin values |
| io_pin_in | input | N_IO | Values seen on the bidirectional pins |
| core_out | input | N_IO | Output values from the core logic |
| core_oe | input | N_IO | Output enables from the core logic |
| io_pin_out | output | N_IO | Value driven to the bidirectional pins |
| io_pin_oe | output | N_IO | Enable for the bidirectional pin drivers |

## Verification
The bench builds the port with three input-only cells and six bidirectional cells, which gives a 21-bit boundary chain, a 20-bit readback register and its own identification and signature constants. At that size a complete chain shift is short enough to repeat over several random pin patterns. Every cell position in the chain is exercised, and preloaded patterns can be checked pin by pin under EXTEST. Because the readback width differs from both fixed registers, a mix-up in register selection or length shows up as a mismatch.

// File: rtl/sigtap_pkg.sv
package sigtap_pkg;

    localparam int IR_W = 4;

    typedef enum logic [3:0] {
        TS_RESET    = 4'h0,
        TS_IDLE     = 4'h1,
        TS_SEL_DR   = 4'h2,
        TS_CAP_DR   = 4'h3,
        TS_SHIFT_DR = 4'h4,
        TS_EXIT1_DR = 4'h5,
        TS_PAUSE_DR = 4'h6,
        TS_EXIT2_DR = 4'h7,
        TS_UPD_DR   = 4'h8,
        TS_SEL_IR   = 4'h9,
        TS_CAP_IR   = 4'hA,
        TS_SHIFT_IR = 4'hB,
        TS_EXIT1_IR = 4'hC,
        TS_PAUSE_IR = 4'hD,
        TS_EXIT2_IR = 4'hE,
        TS_UPD_IR   = 4'hF
    } tap_state_e;

    localparam logic [IR_W-1:0] OP_EXTEST    = 4'h0;
    localparam logic [IR_W-1:0] OP_SAMPLE    = 4'h1;
    localparam logic [IR_W-1:0] OP_IDCODE    = 4'h2;
    localparam logic [IR_W-1:0] OP_HIGHZ     = 4'h3;
    localparam logic [IR_W-1:0] OP_SIGNATURE = 4'h4;
    localparam logic [IR_W-1:0] OP_READBACK  = 4'h5;
    localparam logic [IR_W-1:0] OP_BYPASS    = 4'hF;

    localparam logic [IR_W-1:0] IR_CAPTURE   = 4'b0001;

    typedef enum logic [2:0] {
        DR_BYPASS,
        DR_ID,
        DR_SIG,
        DR_RB,
        DR_BSCAN
    } dr_sel_e;

    typedef struct packed {
        logic cap;
        logic sft;
        logic upd;
    } dr_ctl_t;

    function automatic tap_state_e tap_next(tap_state_e s, logic m);
        tap_state_e n;
        case (s)
            TS_RESET:    n = m ? TS_RESET    : TS_IDLE;
            TS_IDLE:     n = m ? TS_SEL_DR   : TS_IDLE;
            TS_SEL_DR:   n = m ? TS_SEL_IR   : TS_CAP_DR;
            TS_CAP_DR:   n = m ? TS_EXIT1_DR : TS_SHIFT_DR;
            TS_SHIFT_DR: n = m ? TS_EXIT1_DR : TS_SHIFT_DR;
            TS_EXIT1_DR: n = m ? TS_UPD_DR   : TS_PAUSE_DR;
            TS_PAUSE_DR: n = m ? TS_EXIT2_DR : TS_PAUSE_DR;
            TS_EXIT2_DR: n = m ? TS_UPD_DR   : TS_SHIFT_DR;
            TS_UPD_DR:   n = m ? TS_SEL_DR   : TS_IDLE;
            TS_SEL_IR:   n = m ? TS_RESET    : TS_CAP_IR;
            TS_CAP_IR:   n = m ? TS_EXIT1_IR : TS_SHIFT_IR;
            TS_SHIFT_IR: n = m ? TS_EXIT1_IR : TS_SHIFT_IR;
            TS_EXIT1_IR: n = m ? TS_UPD_IR   : TS_PAUSE_IR;
            TS_PAUSE_IR: n = m ? TS_EXIT2_IR : TS_PAUSE_IR;
            TS_EXIT2_IR: n = m ? TS_UPD_IR   : TS_SHIFT_IR;
            TS_UPD_IR:   n = m ? TS_SEL_DR   : TS_IDLE;
            default:     n = TS_RESET;
        endcase
        return n;
    endfunction

    function automatic dr_sel_e dr_decode(logic [IR_W-1:0] op);
        dr_sel_e d;
        case (op)
            OP_EXTEST, OP_SAMPLE: d = DR_BSCAN;
            OP_IDCODE:            d = DR_ID;
            OP_SIGNATURE:         d = DR_SIG;
            OP_READBACK:          d = DR_RB;
            default:              d = DR_BYPASS;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/sigtap_fsm.sv
module sigtap_fsm
    import sigtap_pkg::*;
(
    input  logic       clk,
    input  logic       por,
    input  logic       tms,
    output tap_state_e state
);

    always_ff @(posedge clk) begin
        if (por) state <= TS_RESET;
        else     state <= tap_next(state, tms);
    end

    // checking counter: consecutive TMS-high edges, saturating at five
    logic [2:0] ones_q;
    always_ff @(posedge clk) begin
        if (por)          ones_q <= 3'd0;
        else if (!tms)    ones_q <= 3'd0;
        else if (ones_q != 3'd5) ones_q <= ones_q + 3'd1;
    end

    assert_five_ones_R1: assert property (@(posedge clk) disable iff (por)
        (ones_q == 3'd5) |-> (state == TS_RESET));

    assert_reset_hold_R1: assert property (@(posedge clk) disable iff (por)
        (state == TS_RESET && tms) |=> (state == TS_RESET));

endmodule

// File: rtl/sigtap_ir.sv
module sigtap_ir
    import sigtap_pkg::*;
(
    input  logic            clk,
    input  logic            por,
    input  tap_state_e      state,
    input  logic            tdi,
    output logic            so,
    output logic [IR_W-1:0] op
);

    logic [IR_W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (por) begin
            sh_q <= '0;
        end else if (state == TS_CAP_IR) begin
            sh_q <= IR_CAPTURE;
        end else if (state == TS_SHIFT_IR) begin
            sh_q <= {tdi, sh_q[IR_W-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (por || state == TS_RESET) op <= OP_IDCODE;
        else if (state == TS_UPD_IR)  op <= sh_q;
    end

    assign so = sh_q[0];

    assert_reset_op_R1: assert property (@(posedge clk) disable iff (por)
        (state == TS_RESET) |=> (op == OP_IDCODE));

    assert_ir_capture_R2: assert property (@(posedge clk) disable iff (por)
        (state == TS_CAP_IR) |=> (sh_q[1:0] == 2'b01));

endmodule

// File: rtl/sigtap_shreg.sv
module sigtap_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cap,
    input  logic         sft,
    input  logic         tdi,
    input  logic [W-1:0] cap_val,
    output logic         so
);

    logic [W-1:0] q;

    generate
        if (W == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst)      q <= '0;
                else if (cap) q <= cap_val;
                else if (sft) q <= tdi;
            end
        end else begin : g_wide
            always_ff @(posedge clk) begin
                if (rst)      q <= '0;
                else if (cap) q <= cap_val;
                else if (sft) q <= {tdi, q[W-1:1]};
            end
        end
    endgenerate

    assign so = q[0];

    assert_capture_load_R3: assert property (@(posedge clk) disable iff (rst)
        cap |=> (so == $past(cap_val[0])));

endmodule

// File: rtl/sigtap_bscan.sv
module sigtap_bscan
    import sigtap_pkg::*;
#(
    parameter int N_IN = 4,
    parameter int N_IO = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  dr_ctl_t         ctl,
    input  logic            extest,
    input  logic            highz,
    input  logic            tdi,
    output logic            so,
    input  logic [N_IN-1:0] in_pins,
    input  logic [N_IO-1:0] io_pin_in,
    input  logic [N_IO-1:0] core_out,
    input  logic [N_IO-1:0] core_oe,
    output logic [N_IO-1:0] io_pin_out,
    output logic [N_IO-1:0] io_pin_oe
);

    localparam int CELL_BITS = 3;
    localparam int L = N_IN + CELL_BITS * N_IO;

    logic [L-1:0]    chain_q;
    logic [L-1:0]    cap_v;
    logic [N_IO-1:0] upd_out;
    logic [N_IO-1:0] upd_oe;

    generate
        for (genvar i = 0; i < N_IN; i++) begin : g_in
            assign cap_v[i] = in_pins[i];
        end
        for (genvar k = 0; k < N_IO; k++) begin : g_io
            localparam int B = N_IN + CELL_BITS * k;
            assign cap_v[B]     = io_pin_in[k];
            assign cap_v[B + 1] = core_out[k];
            assign cap_v[B + 2] = core_oe[k];

            always_ff @(posedge clk) begin
                if (rst) begin
                    upd_out[k] <= 1'b0;
                    upd_oe[k]  <= 1'b0;
                end else if (ctl.upd) begin
                    upd_out[k] <= chain_q[B + 1];
                    upd_oe[k]  <= chain_q[B + 2];
                end
            end

            always_comb begin
                io_pin_out[k] = extest ? upd_out[k] : core_out[k];
                if (highz)       io_pin_oe[k] = 1'b0;
                else if (extest) io_pin_oe[k] = upd_oe[k];
                else             io_pin_oe[k] = core_oe[k];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)          chain_q <= '0;
        else if (ctl.cap) chain_q <= cap_v;
        else if (ctl.sft) chain_q <= {tdi, chain_q[L-1:1]};
    end

    assign so = chain_q[0];

    assert_update_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !ctl.upd |=> ($stable(upd_out) && $stable(upd_oe)));

    assert_normal_pass_R11: assert property (@(posedge clk) disable iff (rst)
        (!extest && !highz) |-> (io_pin_out == core_out && io_pin_oe == core_oe));

endmodule

// File: rtl/sigtap.sv
module sigtap
    import sigtap_pkg::*;
#(
    parameter int          N_IN      = 4,
    parameter int          N_IO      = 32,
    parameter int          RB_W      = 32,
    parameter logic [31:0] ID_CODE   = 32'h0D35_A07F,
    parameter logic [15:0] SIG_VALUE = 16'h5A3C
) (
    input  logic            tck,
    input  logic            por,
    input  logic            tms,
    input  logic            tdi,
    output logic            tdo,
    output logic            tdo_en,
    input  logic            lock,
    input  logic [RB_W-1:0] cfg_data,
    input  logic [N_IN-1:0] in_pins,
    input  logic [N_IO-1:0] io_pin_in,
    input  logic [N_IO-1:0] core_out,
    input  logic [N_IO-1:0] core_oe,
    output logic [N_IO-1:0] io_pin_out,
    output logic [N_IO-1:0] io_pin_oe
);

    localparam int ID_W  = 32;
    localparam int SIG_W = 16;
    localparam logic [ID_W-1:0] ID_FIXED = {ID_CODE[ID_W-1:1], 1'b1};

    tap_state_e      state;
    logic [IR_W-1:0] op;
    logic            ir_so;
    dr_sel_e         sel;
    logic            rst_dr;
    logic            cap_dr, sft_dr, upd_dr;
    logic            byp_so, id_so, sig_so, rb_so, bsc_so;
    logic            dr_so;
    logic            shifting;
    logic [RB_W-1:0] rb_cap;
    dr_ctl_t         bsc_ctl;

    sigtap_fsm u_fsm (
        .clk   (tck),
        .por   (por),
        .tms   (tms),
        .state (state)
    );

    sigtap_ir u_ir (
        .clk   (tck),
        .por   (por),
        .state (state),
        .tdi   (tdi),
        .so    (ir_so),
        .op    (op)
    );

    assign sel    = dr_decode(op);
    assign rst_dr = por || (state == TS_RESET);
    assign cap_dr = (state == TS_CAP_DR);
    assign sft_dr = (state == TS_SHIFT_DR);
    assign upd_dr = (state == TS_UPD_DR);
    assign rb_cap = lock ? '0 : cfg_data;

    sigtap_shreg #(.W(1)) u_byp (
        .clk (tck), .rst (rst_dr),
        .cap (cap_dr && sel == DR_BYPASS), .sft (sft_dr && sel == DR_BYPASS),
        .tdi (tdi), .cap_val (1'b0), .so (byp_so)
    );

    sigtap_shreg #(.W(ID_W)) u_id (
        .clk (tck), .rst (rst_dr),
        .cap (cap_dr && sel == DR_ID), .sft (sft_dr && sel == DR_ID),
        .tdi (tdi), .cap_val (ID_FIXED), .so (id_so)
    );

    sigtap_shreg #(.W(SIG_W)) u_sig (
        .clk (tck), .rst (rst_dr),
        .cap (cap_dr && sel == DR_SIG), .sft (sft_dr && sel == DR_SIG),
        .tdi (tdi), .cap_val (SIG_VALUE), .so (sig_so)
    );

    sigtap_shreg #(.W(RB_W)) u_rb (
        .clk (tck), .rst (rst_dr),
        .cap (cap_dr && sel == DR_RB), .sft (sft_dr && sel == DR_RB),
        .tdi (tdi), .cap_val (rb_cap), .so (rb_so)
    );

    assign bsc_ctl.cap = cap_dr && sel == DR_BSCAN;
    assign bsc_ctl.sft = sft_dr && sel == DR_BSCAN;
    assign bsc_ctl.upd = upd_dr && sel == DR_BSCAN;

    sigtap_bscan #(.N_IN(N_IN), .N_IO(N_IO)) u_bsc (
        .clk        (tck),
        .rst        (rst_dr),
        .ctl        (bsc_ctl),
        .extest     (op == OP_EXTEST),
        .highz      (op == OP_HIGHZ),
        .tdi        (tdi),
        .so         (bsc_so),
        .in_pins    (in_pins),
        .io_pin_in  (io_pin_in),
        .core_out   (core_out),
        .core_oe    (core_oe),
        .io_pin_out (io_pin_out),
        .io_pin_oe  (io_pin_oe)
    );

    always_comb begin
        case (sel)
            DR_ID:    dr_so = id_so;
            DR_SIG:   dr_so = sig_so;
            DR_RB:    dr_so = rb_so;
            DR_BSCAN: dr_so = bsc_so;
            default:  dr_so = byp_so;
        endcase
    end

    assign shifting = (state == TS_SHIFT_DR) || (state == TS_SHIFT_IR);

    always_ff @(negedge tck) begin
        if (por) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo    <= shifting ? ((state == TS_SHIFT_IR) ? ir_so : dr_so) : 1'b0;
            tdo_en <= shifting;
        end
    end

    assert_tdo_window_R10: assert property (@(posedge tck) disable iff (por)
        tdo_en == ((state == TS_SHIFT_DR) || (state == TS_SHIFT_IR)));

    assert_highz_float_R7: assert property (@(posedge tck) disable iff (por)
        (op == OP_HIGHZ) |-> (io_pin_oe == '0));

    assert_lock_blank_R9: assert property (@(posedge tck) disable iff (por)
        (state == TS_SHIFT_DR && $past(state) == TS_CAP_DR && $past(lock)
         && op == OP_READBACK) |-> (rb_so == 1'b0));

endmodule

// File: tb/sigtap_tb.sv
`timescale 1ns/1ps
module sigtap_tb;

    localparam int NI  = 3;
    localparam int NO  = 6;
    localparam int L   = NI + 3 * NO;
    localparam int RBW = 20;
    localparam logic [31:0] IDV = 32'h2B71_A0C3;
    localparam logic [15:0] SGV = 16'hC35A;

    logic tck = 1'b0;
    logic por = 1'b1;
    logic tms = 1'b1;
    logic tdi = 1'b0;
    logic lock = 1'b0;
    logic [RBW-1:0] cfg = '0;
    logic [NI-1:0]  pins = '0;
    logic [NO-1:0]  io_in = '0, c_out = '0, c_oe = '0;
    logic tdo, tdo_en;
    logic [NO-1:0] pout, poe;

    int checks = 0;
    int fails  = 0;
    int en_bad = 0;
    bit done   = 0;

    always #2.5 tck = ~tck;

    sigtap #(.N_IN(NI), .N_IO(NO), .RB_W(RBW), .ID_CODE(IDV), .SIG_VALUE(SGV)) u_dut (
        .tck (tck), .por (por), .tms (tms), .tdi (tdi), .tdo (tdo), .tdo_en (tdo_en),
        .lock (lock), .cfg_data (cfg), .in_pins (pins), .io_pin_in (io_in),
        .core_out (c_out), .core_oe (c_oe), .io_pin_out (pout), .io_pin_oe (poe)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d, output logic o, output logic e);
        @(negedge tck); #1;
        o = tdo; e = tdo_en;
        tms = m; tdi = d;
        @(posedge tck); #1;
    endtask

    task automatic go(input logic m);
        logic o, e;
        step(m, 1'b0, o, e);
    endtask

    task automatic shift_ir(input logic [3:0] d, output logic [3:0] q);
        logic e;
        go(1); go(1); go(0); go(0);
        for (int j = 0; j < 4; j++) begin
            step(j == 3, d[j], q[j], e);
            if (!e) en_bad++;
        end
        go(1); go(0);
    endtask

    task automatic shift_dr(input int n, input logic [63:0] d, output logic [63:0] q);
        logic e;
        q = '0;
        go(1); go(0); go(0);
        for (int j = 0; j < n; j++) begin
            step(j == n - 1, d[j], q[j], e);
            if (!e) en_bad++;
        end
        go(1); go(0);
    endtask

    function automatic logic [L-1:0] cap_vec();
        logic [L-1:0] v;
        for (int i = 0; i < NI; i++) v[i] = pins[i];
        for (int k = 0; k < NO; k++) begin
            v[NI + 3*k]     = io_in[k];
            v[NI + 3*k + 1] = c_out[k];
            v[NI + 3*k + 2] = c_oe[k];
        end
        return v;
    endfunction

    function automatic logic [NO-1:0] pick(input logic [L-1:0] v, input int off);
        logic [NO-1:0] r;
        for (int k = 0; k < NO; k++) r[k] = v[NI + 3*k + off];
        return r;
    endfunction

    task automatic randomize_pins();
        pins  = NI'($urandom);
        io_in = NO'($urandom);
        c_out = NO'($urandom);
        c_oe  = NO'($urandom);
    endtask

    task automatic bypass_check(input string tag);
        logic [63:0] q, d;
        d = 64'($urandom & 32'hFF);
        shift_dr(9, d, q);
        check(q[8:0] == {d[7:0], 1'b0}, tag, 64'(q[8:0]), 64'({d[7:0], 1'b0}));
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [3:0]  q4;
        logic [63:0] q;
        logic [L-1:0] p;
        void'($urandom(32'd1502));
        randomize_pins();
        repeat (3) @(posedge tck);
        @(negedge tck); por = 1'b0;
        @(posedge tck); #1;

        // R11 and R10: reset state
        check(pout == c_out && poe == c_oe, "R11 reset pass", 64'({pout, poe}), 64'({c_out, c_oe}));
        check(tdo_en == 1'b0, "R10 reset tdo_en", 64'(tdo_en), 64'd0);
        go(0);

        // R3: IDCODE selected after reset
        shift_dr(32, 64'd0, q);
        check(q[31:0] == IDV, "R3 idcode", q, 64'(IDV));
        check(q[0] == 1'b1, "R3 id bit0", 64'(q[0]), 64'd1);

        // R2: IR capture pattern
        shift_ir(4'hF, q4);
        check(q4[1:0] == 2'b01, "R2 ir capture", 64'(q4), 64'(4'b0001));

        // R4: bypass and unknown opcode
        bypass_check("R4 bypass");
        shift_ir(4'hA, q4);
        bypass_check("R4 unknown opcode");

        // R5: sample captures
        for (int it = 0; it < 4; it++) begin
            randomize_pins();
            shift_ir(4'h1, q4);
            shift_dr(L, 64'd0, q);
            check(q[L-1:0] == cap_vec(), "R5 sample capture", 64'(q[L-1:0]), 64'(cap_vec()));
            check(pout == c_out && poe == c_oe, "R11 sample pass", 64'({pout, poe}), 64'({c_out, c_oe}));
        end

        // R6: preload then extest
        for (int it = 0; it < 3; it++) begin
            shift_ir(4'h1, q4);
            p = L'({$urandom, $urandom});
            shift_dr(L, 64'(p), q);
            shift_ir(4'h0, q4);
            check(pout == pick(p, 1) && poe == pick(p, 2), "R6 extest drive",
                  64'({pout, poe}), 64'({pick(p, 1), pick(p, 2)}));
            c_out = ~c_out; c_oe = ~c_oe;
            #1;
            check(pout == pick(p, 1) && poe == pick(p, 2), "R6 core ignored",
                  64'({pout, poe}), 64'({pick(p, 1), pick(p, 2)}));
        end
        shift_ir(4'h1, q4);
        check(pout == c_out && poe == c_oe, "R11 leave extest", 64'({pout, poe}), 64'({c_out, c_oe}));

        // R7: highz
        c_oe = '1; #1;
        shift_ir(4'h3, q4);
        check(poe == '0, "R7 highz oe", 64'(poe), 64'd0);
        bypass_check("R7 highz bypass");

        // R8: signature regardless of lock
        lock = 1'b1;
        shift_ir(4'h4, q4);
        shift_dr(16, 64'd0, q);
        check(q[15:0] == SGV, "R8 sig locked", q, 64'(SGV));
        lock = 1'b0;
        shift_dr(16, 64'd0, q);
        check(q[15:0] == SGV, "R8 sig unlocked", q, 64'(SGV));

        // R9: readback gated by lock
        shift_ir(4'h5, q4);
        for (int it = 0; it < 2; it++) begin
            cfg = RBW'($urandom);
            lock = 1'b0;
            shift_dr(RBW, 64'd0, q);
            check(q[RBW-1:0] == cfg, "R9 readback open", q, 64'(cfg));
            lock = 1'b1;
            shift_dr(RBW, 64'd0, q);
            check(q[RBW-1:0] == '0, "R9 readback locked", q, 64'd0);
        end
        lock = 1'b0;

        // R1: five TMS-high edges from mid shift return to reset
        shift_ir(4'hF, q4);
        go(1); go(0); go(0);
        repeat (5) go(1);
        go(0);
        shift_dr(32, 64'd0, q);
        check(q[31:0] == IDV, "R1 tms reset", q, 64'(IDV));

        // R10: tdo_en window
        check(en_bad == 0, "R10 tdo_en in shift", 64'(en_bad), 64'd0);
        @(negedge tck); #1;
        check(tdo_en == 1'b0, "R10 tdo_en idle", 64'(tdo_en), 64'd0);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule